// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into a stream of column addresses, one for each data beat, at a rate of one beat per clock. A command carries an 8-bit starting column, a burst-length code, a wrap-order select and a read/write flag. The first beat appears on the clock after the command. The column of each later beat follows either the wrapping sequential order or the interleaved (XOR) order inside the block that the burst length aligns to.

The generator flags the final beat of a burst. A full-page burst covers every column of the row. It repeats until it is stopped, and it has no final beat of its own. A burst-stop or precharge pulse ends the current burst early. A fresh column command restarts generation on any clock and drops whatever remained of the old burst. A mode input makes every write burst one beat long. Command decoding, CAS-latency alignment and the data path are handled by neighbouring blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and until the first command, `beat_valid_o` and `last_o` are low.
- R2: On the clock after `start_i` is sampled high, `beat_valid_o` is high and `col_o` equals the sampled `start_col_i`.
- R3: `len_code_i` gives the burst length as follows: 0 means 1 beat, 1 means 2, 2 means 4, 3 means 8 and 7 means full page (256 beats). The reserved codes 4, 5 and 6 behave as 1 beat.
- R4: In sequential order (`interleave_i` = 0), the low log2(length) bits of the column count up from the start and wrap inside the aligned block. The bits above that span keep their start value. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R5: In interleaved order (`interleave_i` = 1), the low log2(length) bits of beat k are the start's low bits XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R6: A full-page burst always counts sequentially, whatever `interleave_i` says. It wraps from 255 to 0, never raises `last_o`, and runs until it is stopped or restarted.
- R7: When `single_write_i` is high at the command, a write command (`write_i` = 1) gives exactly one beat, whatever the length code. A read command keeps its programmed length.
- R8: `last_o` is high only on the final beat of a burst that is not full page, and it is high on the first beat when the length is 1. After the final beat, `beat_valid_o` is low unless a new command was given.
- R9: If `stop_i` is high while a beat is being presented and no command arrives in that cycle, that beat is the last one presented. `beat_valid_o` is low on the next clock.
- R10: A command given during a burst starts the new burst on the next clock, with its beat index reset to 0. When `start_i` and `stop_i` are high together, the command takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe |
| start_col_i | input | 8 | Starting column address |
| len_code_i | input | 3 | Burst-length code (see R3) |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| write_i | input | 1 | 1 marks the command as a write |
| single_write_i | input | 1 | Mode: write bursts are one beat long |
| stop_i | input | 1 | Burst stop or precharge interrupt |
| beat_valid_o | output | 1 | A beat address is presented this cycle |
| col_o | output | 8 | Column address of the current beat |
| last_o | output | 1 | The current beat is the final one of the burst |

## Verification
A beat counter that is off by one shows up on `col_o` on the very next beat. It also moves `last_o` by one cycle, so the burst becomes one beat too long or too short. A wrong latched length or order appears on the second or third beat: the column crosses its aligned block, or it follows the wrong sequence. A corrupted active state shows up as beats that continue past a stop or past the final beat, or as beats that never arrive. Every such fault is visible at the ports within one clock of the event that should have acted.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  typedef logic [LEN_CODE_W-1:0] len_code_t;
  localparam len_code_t LEN_ONE   = 3'd0;
  localparam len_code_t LEN_TWO   = 3'd1;
  localparam len_code_t LEN_FOUR  = 3'd2;
  localparam len_code_t LEN_EIGHT = 3'd3;
  localparam len_code_t LEN_PAGE  = 3'd7;
endpackage

// File: rtl/sdram_len_decode.sv
module sdram_len_decode
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  len_code_t        len_code,
  input  logic             is_write,
  input  logic             single_write,
  input  logic             interleave,
  output logic [COL_W-1:0] span_mask,
  output logic             full_page,
  output logic             inter_eff
);
  logic force_one;
  assign force_one = is_write & single_write;

  always_comb begin
    span_mask = '0;
    full_page = 1'b0;
    if (!force_one) begin
      case (len_code)
        LEN_TWO:   span_mask = COL_W'(1);
        LEN_FOUR:  span_mask = COL_W'(3);
        LEN_EIGHT: span_mask = COL_W'(7);
        LEN_PAGE: begin
          span_mask = '1;
          full_page = 1'b1;
        end
        default:   span_mask = '0;
      endcase
    end
  end

  // full page is sequential only
  assign inter_eff = interleave & ~full_page;
endmodule

// File: rtl/sdram_beat_seq.sv
module sdram_beat_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] col_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             inter_in,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             inter,
  output logic             full,
  output logic             final_beat,
  output logic             done,
  output logic             cut
);
  assign final_beat = active & ~full & (idx == mask);
  assign done       = final_beat & ~start;
  assign cut        = active & stop & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      mask   <= '0;
      inter  <= 1'b0;
      full   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= col_in;
      mask   <= mask_in;
      inter  <= inter_in;
      full   <= full_in;
    end else if (active) begin
      if (done || cut) begin
        active <= 1'b0;
      end else begin
        idx <= idx + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             inter,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b,
    input logic [COL_W-1:0] k,
    input logic [COL_W-1:0] m,
    input logic             x
  );
    logic [COL_W-1:0] low;
    low = x ? (b ^ k) : (b + k);
    return (b & ~m) | (low & m);
  endfunction

  assign col = beat_col(base, idx, mask, inter);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             write_i,
  input  logic             single_write_i,
  input  logic             stop_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_inter;
  logic             seq_active;
  logic [COL_W-1:0] seq_idx;
  logic [COL_W-1:0] seq_base;
  logic [COL_W-1:0] seq_mask;
  logic             seq_inter;
  logic             seq_full;
  logic             seq_final;
  logic             seq_done;
  logic             seq_cut;

  sdram_len_decode #(.COL_W(COL_W)) i_dec (
    .len_code     (len_code_t'(len_code_i)),
    .is_write     (write_i),
    .single_write (single_write_i),
    .interleave   (interleave_i),
    .span_mask    (dec_mask),
    .full_page    (dec_full),
    .inter_eff    (dec_inter)
  );

  sdram_beat_seq #(.COL_W(COL_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .stop       (stop_i),
    .col_in     (start_col_i),
    .mask_in    (dec_mask),
    .full_in    (dec_full),
    .inter_in   (dec_inter),
    .active     (seq_active),
    .idx        (seq_idx),
    .base       (seq_base),
    .mask       (seq_mask),
    .inter      (seq_inter),
    .full       (seq_full),
    .final_beat (seq_final),
    .done       (seq_done),
    .cut        (seq_cut)
  );

  sdram_col_map #(.COL_W(COL_W)) i_map (
    .base  (seq_base),
    .idx   (seq_idx),
    .mask  (seq_mask),
    .inter (seq_inter),
    .col   (col_o)
  );

  assign beat_valid_o = seq_active;
  assign last_o       = seq_final;

  // seq_full is consumed inside the sequencer; kept for observation
  logic unused_full;
  assign unused_full = seq_full;
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             write_i,
  input logic             single_write_i,
  input logic             stop_i,
  input logic             beat_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             last_o,
  input logic             seq_done,
  input logic             seq_cut
);
  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_valid_o && col_o == $past(start_col_i));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);

  // R8
  after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !beat_valid_o);

  // R8
  keep_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !last_o && !stop_i && !start_i |=> beat_valid_o);

  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cut |=> !beat_valid_o);

  // R6
  page_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && len_code_i == LEN_PAGE && !(write_i && single_write_i) |=> !last_o);

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && write_i && single_write_i |=> last_o);

  // R3
  len_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && len_code_i == LEN_ONE |=> last_o);
endmodule

bind sdram_burst_colgen sdram_colgen_chk #(.COL_W(COL_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .start_col_i    (start_col_i),
  .len_code_i     (len_code_i),
  .write_i        (write_i),
  .single_write_i (single_write_i),
  .stop_i         (stop_i),
  .beat_valid_o   (beat_valid_o),
  .col_o          (col_o),
  .last_o         (last_o),
  .seq_done       (seq_done),
  .seq_cut        (seq_cut)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       write_i = 1'b0;
  logic       single_write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       beat_valid_o;
  logic [7:0] col_o;
  logic       last_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state after the next edge
  bit m_act = 0;
  int m_idx, m_base, m_len;
  bit m_inter, m_full;

  always #2 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .write_i(write_i),
    .single_write_i(single_write_i), .stop_i(stop_i),
    .beat_valid_o(beat_valid_o), .col_o(col_o), .last_o(last_o)
  );

  function automatic int code_len(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int off, blk;
    if (m_full) return (m_base + m_idx) % 256;
    off = m_base % m_len;
    blk = m_base - off;
    if (m_inter) return blk + (off ^ m_idx);
    return blk + ((off + m_idx) % m_len);
  endfunction

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive one cycle, advance the model, check after the edge
  task automatic step(bit st, int col, int code, bit il, bit wr, bit sw, bit sp);
    bit m_last;
    start_i = st; start_col_i = 8'(col); len_code_i = 3'(code);
    interleave_i = il; write_i = wr; single_write_i = sw; stop_i = sp;
    m_last = m_act && !m_full && (m_idx == m_len - 1);
    if (st) begin
      m_act = 1; m_idx = 0; m_base = col;
      m_full = (code == 7) && !(wr && sw);
      m_len = (wr && sw) ? 1 : code_len(code);
      m_inter = il && !m_full;
    end else if (m_act) begin
      if (sp || m_last) m_act = 0;
      else m_idx = (m_idx + 1) % 256;
    end
    @(negedge clk);
    chk({tag, " valid"}, beat_valid_o, m_act);
    if (m_act) begin
      chk({tag, " col"}, col_o, exp_col());
      chk({tag, " last"}, last_o, !m_full && (m_idx == m_len - 1));
    end else begin
      chk({tag, " last"}, last_o, 0);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    @(negedge clk);
    tag = "R1";
    chk("R1 reset valid", beat_valid_o, 0);
    chk("R1 reset last", last_o, 0);
    rst_n = 1'b1;
    idle(2);
    // R2 R4 sequential start 5, BL8
    tag = "R4"; step(1, 5, 3, 0, 0, 0, 0);
    chk("R2 first col", col_o, 5);
    idle(8);
    // R4 upper bits kept, BL4 from 0xAD
    step(1, 8'hAD, 2, 0, 0, 0, 0); idle(4);
    // R5 interleave start 5, BL8
    tag = "R5"; step(1, 5, 3, 1, 0, 0, 0); idle(8);
    step(1, 8'h6B, 2, 1, 1, 0, 0); idle(4);
    // R3 every code including reserved
    tag = "R3";
    for (int c = 0; c < 8; c++) begin
      step(1, 8'h33, c, 0, 0, 0, 0);
      idle(c == 7 ? 3 : 9);
      if (c == 7) step(0, 0, 0, 0, 0, 0, 1);
      idle(1);
    end
    // R6 full page, interleave ignored, wraps past 255
    tag = "R6"; step(1, 8'hFE, 7, 1, 0, 0, 0); idle(259);
    step(0, 0, 0, 0, 0, 0, 1); idle(2);
    // R7 single write mode: write one beat, read full length
    tag = "R7"; step(1, 8'h12, 3, 0, 1, 1, 0); idle(2);
    step(1, 8'h12, 7, 0, 1, 1, 0); idle(2);
    step(1, 8'h12, 2, 0, 0, 1, 0); idle(5);
    // R8 back-to-back length-1 bursts
    tag = "R8"; step(1, 1, 0, 0, 0, 0, 0); step(1, 2, 0, 0, 0, 0, 0); idle(2);
    // R9 stop mid burst
    tag = "R9"; step(1, 8'h40, 3, 0, 0, 0, 0); idle(2);
    step(0, 0, 0, 0, 0, 0, 1); idle(2);
    // R10 restart mid burst, and start with stop together
    tag = "R10"; step(1, 8'h40, 3, 0, 0, 0, 0); idle(2);
    step(1, 8'h93, 2, 1, 0, 0, 0); idle(1);
    step(1, 8'h20, 3, 0, 0, 0, 1); idle(9);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit st, sp, il, wr, sw;
      int code, col;
      st = ($urandom % 6) == 0;
      sp = ($urandom % 20) == 0;
      il = $urandom % 2; wr = $urandom % 2; sw = ($urandom % 4) == 0;
      code = $urandom % 8; col = $urandom % 256;
      if (st) begin
        if (wr && sw) tag = "R7";
        else if (code == 7) tag = "R6";
        else if (il) tag = "R5";
        else tag = "R4";
      end
      step(st, col, code, il, wr, sw, sp);
    end
    summary();
  end
endmodule